// File: doc/BRIEF.md
# Zero-Crossing Gated Wiper Update Controller

This block sits between a serial configuration port and two audio attenuator channels. The port presents two pending wiper codes and a one-cycle load strobe, which marks the end of a serial transfer. The block decides, for each channel separately, the cycle in which the pending code becomes the active wiper code. When gating is on, a channel holds its new code until its own zero-crossing input reports that the signal across the attenuator is at zero. Switching at that point keeps the step from being heard as a click.

A single window timer limits how long a channel may wait. It starts counting on the load strobe. If a channel has seen no crossing by the end of the window, its update is forced. A bypass input turns the gating off. While bypass is high, a load applies its codes at once and the timer plays no part. Each code is seven bits. Values 0 to 63 are attenuation steps, and bit 6 set (64 and above) means mute.

Top module: `zcg_wiper_ctrl`

## Requirements
- R1: After reset both active wiper codes are 63, no update pulse is asserted and no channel is waiting.
- R2: With bypass high, a load whose pending code differs from a channel's active code pulses that channel's update output in the load cycle. The new code appears on the wiper output from the next cycle.
- R3: With bypass low, a load starts a wait for each channel whose pending code differs from its active code. The channel updates in the first later cycle in which its zero-crossing input is high. A crossing that arrives in the load cycle itself is ignored.
- R4: With bypass low, a waiting channel that sees no crossing is updated in cycle L+WIN_CYCLES, where L is the cycle of the most recent load.
- R5: The two channels release independently. A crossing on one channel does not release the other. Both channels may time out in the same cycle.
- R6: A load that arrives while a channel is waiting replaces that channel's pending code and restarts the window from the new load.
- R7: A load whose pending code equals the active code causes no update pulse and leaves that channel idle.
- R8: A wiper output changes only in the cycle after that channel's update pulse. Every update pulse lasts one cycle and changes the code.
- R9: If bypass rises while a channel is waiting, that channel is released in that same cycle.
- R10: A zero-crossing input has no effect on a channel that is not waiting.
- R11: All seven code bits are carried through unchanged, so the mute code 64 reaches the wiper output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle strobe: pending codes are valid |
| bypass_i | input | 1 | High turns off zero-crossing gating and the timeout |
| zc0_i | input | 1 | Zero-crossing event, channel 0 |
| zc1_i | input | 1 | Zero-crossing event, channel 1 |
| pend0_i | input | 7 | Pending code, channel 0 |
| pend1_i | input | 7 | Pending code, channel 1 |
| wiper0_o | output | 7 | Active code, channel 0 |
| wiper1_o | output | 7 | Active code, channel 1 |
| upd0_o | output | 1 | One-cycle update pulse, channel 0 |
| upd1_o | output | 1 | One-cycle update pulse, channel 1 |

## Verification
The bench drives the two channels in several patterns:
- Loads with bypass high, to separate the immediate path from the gated path.
- A gated load where one channel gets a crossing and the other does not. This shows that the channels release independently and that the timeout lands in exactly cycle L+WIN.
- A reload in the middle of a wait, which shows whether the window restarts.
- A crossing that coincides with the load strobe, and crossings while both channels are idle. These show that a crossing counts only while a channel is waiting.
- Loads of codes equal to the active ones, and a bypass edge during a wait, which cover the suppressed and early-release paths.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int CODE_W     = 7;
  localparam int RESET_CODE = 63;
  localparam int NCH        = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {CH_IDLE = 1'b0, CH_WAIT = 1'b1} ch_state_e;

  function automatic logic code_differs(code_t a, code_t b);
    return a != b;
  endfunction

  function automatic logic release_now(ch_state_e st, logic zc, logic expired, logic bypass);
    return (st == CH_WAIT) && (zc || expired || bypass);
  endfunction
endpackage

// File: rtl/zcg_window_timer.sv
module zcg_window_timer #(
  parameter int WIN_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic busy_i,
  output logic expired_o
);
  localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = busy_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= '0;
    else if (busy_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/zcg_channel.sv
module zcg_channel
  import zcg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  bypass_i,
  input  logic  zc_i,
  input  logic  expired_i,
  input  code_t pend_i,
  output code_t wiper_o,
  output logic  upd_o,
  output logic  waiting_o
);
  ch_state_e st_q, st_d;
  code_t     held_q, act_q;
  logic      differs, fire_direct, fire_held;

  always_comb begin
    differs     = code_differs(pend_i, act_q);
    fire_direct = load_i && bypass_i && differs;
    fire_held   = !load_i && release_now(st_q, zc_i, expired_i, bypass_i);
    st_d        = st_q;
    if (load_i)         st_d = (differs && !bypass_i) ? CH_WAIT : CH_IDLE;
    else if (fire_held) st_d = CH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      held_q <= code_t'(RESET_CODE);
      act_q  <= code_t'(RESET_CODE);
    end else begin
      st_q <= st_d;
      if (load_i)           held_q <= pend_i;
      if (fire_direct)      act_q  <= pend_i;
      else if (fire_held)   act_q  <= held_q;
    end
  end

  assign upd_o     = fire_direct || fire_held;
  assign wiper_o   = act_q;
  assign waiting_o = (st_q == CH_WAIT);
endmodule

// File: rtl/zcg_wiper_ctrl.sv
module zcg_wiper_ctrl #(
  parameter int WIN_CYCLES = 5_000_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic                      bypass_i,
  input  logic                      zc0_i,
  input  logic                      zc1_i,
  input  logic [zcg_pkg::CODE_W-1:0] pend0_i,
  input  logic [zcg_pkg::CODE_W-1:0] pend1_i,
  output logic [zcg_pkg::CODE_W-1:0] wiper0_o,
  output logic [zcg_pkg::CODE_W-1:0] wiper1_o,
  output logic                      upd0_o,
  output logic                      upd1_o
);
  import zcg_pkg::*;

  code_t            pend_a [NCH];
  code_t            wip_a  [NCH];
  logic [NCH-1:0]   zc_a, upd_a, waiting_w;
  logic             expired_w;

  assign pend_a[0] = pend0_i;
  assign pend_a[1] = pend1_i;
  assign zc_a      = {zc1_i, zc0_i};

  zcg_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .busy_i(|waiting_w), .expired_o(expired_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    zcg_channel u_ch (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .bypass_i(bypass_i),
      .zc_i(zc_a[g]), .expired_i(expired_w), .pend_i(pend_a[g]),
      .wiper_o(wip_a[g]), .upd_o(upd_a[g]), .waiting_o(waiting_w[g])
    );
  end

  assign wiper0_o = wip_a[0];
  assign wiper1_o = wip_a[1];
  assign upd0_o   = upd_a[0];
  assign upd1_o   = upd_a[1];
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       bypass,
  input logic [6:0] pend0,
  input logic [6:0] wiper0,
  input logic [6:0] wiper1,
  input logic       upd0,
  input logic       upd1,
  input logic [1:0] waiting,
  input logic       expired
);
  AST_HOLD_WITHOUT_PULSE0: assert property (@(posedge clk) disable iff (!rst_n)
    !upd0 |=> wiper0 == $past(wiper0)); // R8
  AST_HOLD_WITHOUT_PULSE1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd1 |=> wiper1 == $past(wiper1)); // R8
  AST_PULSE_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    upd0 |=> wiper0 != $past(wiper0)); // R7
  AST_GATED_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load && !bypass |-> !upd0 && !upd1); // R3
  AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    waiting[1] && expired && !load |-> upd1); // R4
  AST_BYPASS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && load && (pend0 != wiper0) |-> upd0); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting[0] && !load |-> !upd0); // R10
endmodule

bind zcg_wiper_ctrl zcg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_i), .bypass(bypass_i),
  .pend0(pend0_i), .wiper0(wiper0_o), .wiper1(wiper1_o),
  .upd0(upd0_o), .upd1(upd1_o), .waiting(waiting_w), .expired(expired_w)
);

// File: tb/sim_zcg_wiper_ctrl.sv
module sim_zcg_wiper_ctrl;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;

  typedef struct { int code; int cyc; string req; } exp_t;

  logic clk = 0, rst_n = 0, load = 0, bypass = 0, zc0 = 0, zc1 = 0;
  logic [6:0] pend0 = 0, pend1 = 0, wiper0, wiper1;
  logic upd0, upd1;
  int cyc = 0, n_chk = 0, n_err = 0, c, c2;
  bit done = 0;
  exp_t qs [2][$];
  bit   chk_pend [2];
  int   chk_code [2];
  int   act [2];
  logic [6:0] wv [2];
  logic       uv [2];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zcg_wiper_ctrl #(.WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load), .bypass_i(bypass),
    .zc0_i(zc0), .zc1_i(zc1), .pend0_i(pend0), .pend1_i(pend1),
    .wiper0_o(wiper0), .wiper1_o(wiper1), .upd0_o(upd0), .upd1_o(upd1)
  );

  assign wv[0] = wiper0; assign wv[1] = wiper1;
  assign uv[0] = upd0;   assign uv[1] = upd1;

  task automatic check(bit ok, string req, int actual, int expected);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic at(int base, int k);
    while (cyc < base + k) step(1);
  endtask

  task automatic push(int ch, int code, int when, string req);
    exp_t e;
    e.code = code; e.cyc = when; e.req = req;
    qs[ch].push_back(e);
    act[ch] = code;
  endtask

  // Scoreboard monitor: samples mid-cycle, away from the clock edge
  always @(negedge clk) if (rst_n && !done) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (chk_pend[ch]) begin
        check(wv[ch] == 7'(chk_code[ch]), "R8 wiper after pulse", wv[ch], chk_code[ch]);
        chk_pend[ch] = 0;
      end
      if (uv[ch]) begin
        if (qs[ch].size() == 0) check(0, "R10 unexpected pulse", ch, -1);
        else begin
          exp_t e;
          e = qs[ch].pop_front();
          check(cyc == e.cyc, e.req, cyc, e.cyc);
          chk_pend[ch] = 1;
          chk_code[ch] = e.code;
        end
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    act[0] = 63; act[1] = 63;
    step(3); rst_n = 1; step(1);
    // R1 reset state
    check(wiper0 == 63, "R1 wiper0", wiper0, 63);
    check(wiper1 == 63, "R1 wiper1", wiper1, 63);
    check(!upd0 && !upd1, "R1 pulses", {upd1, upd0}, 0);

    // R2 bypass: immediate, R7 equal channel silent
    bypass = 1; pend0 = 10; pend1 = 63; load = 1; c = cyc;
    push(0, 10, c, "R2 bypass immediate");
    step(1); load = 0; step(3); bypass = 0;
    check(wiper1 == 63, "R7 equal code untouched", wiper1, 63);

    // R3 crossing on ch0, R4 timeout on ch1, R5 independence
    pend0 = 20; pend1 = 30; load = 1; c = cyc;
    step(1); load = 0;
    at(c, 3); zc0 = 1; push(0, 20, c + 3, "R3 crossing release");
    push(1, 30, c + WIN, "R4 timeout release R5");
    step(1); zc0 = 0;
    at(c, WIN + 4);

    // R6 reload restarts window
    pend0 = 40; pend1 = 41; load = 1; c = cyc;
    step(1); load = 0;
    at(c, 5); pend0 = 45; load = 1; c2 = cyc;
    step(1); load = 0;
    at(c, 8); zc1 = 1; push(1, 41, c + 8, "R6 reload crossing");
    push(0, 45, c2 + WIN, "R6 restarted window");
    step(1); zc1 = 0;
    at(c2, WIN + 4);

    // R3 crossing in load cycle ignored
    pend0 = 50; pend1 = 7'(act[1]); load = 1; zc0 = 1; c = cyc;
    step(1); load = 0; zc0 = 0;
    at(c, 2); zc0 = 1; push(0, 50, c + 2, "R3 load-cycle crossing ignored");
    step(1); zc0 = 0; step(3);

    // R10 crossings while idle
    zc0 = 1; zc1 = 1; step(6); zc0 = 0; zc1 = 0; step(1);
    check(wiper0 == 50, "R10 idle ch0", wiper0, 50);
    check(wiper1 == 41, "R10 idle ch1", wiper1, 41);

    // R9 bypass rises while waiting
    pend0 = 50; pend1 = 5; load = 1; c = cyc;
    step(1); load = 0;
    at(c, 4); bypass = 1; push(1, 5, c + 4, "R9 bypass release");
    step(1); bypass = 0; step(3);

    // R7 equal codes under gating: nothing happens
    pend0 = 50; pend1 = 5; load = 1;
    step(1); load = 0; step(WIN + 6);
    check(wiper0 == 50, "R7 equal gated ch0", wiper0, 50);
    check(wiper1 == 5, "R7 equal gated ch1", wiper1, 5);

    // R5 both time out together, R11 mute code
    pend0 = 64; pend1 = 2; load = 1; c = cyc;
    push(0, 64, c + WIN, "R5 joint timeout ch0");
    push(1, 2, c + WIN, "R5 joint timeout ch1");
    step(1); load = 0; at(c, WIN + 4);
    check(wiper0 == 64, "R11 mute code", wiper0, 64);

    check(qs[0].size() == 0, "R5 ch0 pulses outstanding", qs[0].size(), 0);
    check(qs[1].size() == 0, "R5 ch1 pulses outstanding", qs[1].size(), 0);
    summary();
  end
endmodule